// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits between ten peripheral interrupt flags and an 8-bit processor core. It samples the flags every clock. It masks them with a per-source enable and one global enable. It then picks a single winner and presents it to the core as a request plus a 16-bit vector address. Each source carries a two-bit priority made of a high bit and a low bit, which gives four levels. Level 3 is the most urgent.

The controller keeps a four-bit in-service mask, with one bit per level. This mask lets it nest handlers. A new request is issued only when its level is strictly above every level that is currently in service. When the core enters a handler, it pulses an acknowledge, and the level of the served request is marked in service. When the handler exits, the core pulses a return strobe, and the highest in-service level is released. The request output and its vector stay frozen from the cycle they are issued until the acknowledge.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is low and no level is in service. The first enabled request at level 0 is therefore issued.
- R2: Source i (bit i of every per-source port, i = 0..9) is issued with `irq_vec` = 0x0003 + 8*i, so the vectors run from 0x0003 for source 0 to 0x004B for source 9.
- R3: A flag on source i can be issued only while `src_en[i]` is 1 and `glb_en` is 1.
- R4: The level of source i is {`prio_hi[i]`, `prio_lo[i]`}, where 0 is the lowest and 3 the highest. Among simultaneous eligible requests, the highest level wins.
- R5: Among eligible requests of equal level, the source with the lowest index wins.
- R6: A request is eligible only if its level is strictly greater than the highest level in service. A request at an equal or lower level waits.
- R7: While level 3 is in service, no request is issued.
- R8: Once `irq_req` rises, it stays high and `irq_vec` stays unchanged until a cycle with `irq_ack` high. After that cycle, `irq_req` is low, and the acknowledged level is in service.
- R9: A cycle with `irq_ret` high removes the highest in-service level and leaves the lower levels in service. Waiting requests at or below the released level can then be issued.
- R10: While `glb_en` is low, no new request is issued, and the in-service mask is unchanged apart from acknowledge and return.
- R11: A flag that rises when no level is in service and `irq_req` is low makes `irq_req` high after the second rising clock edge that samples it. The first edge latches the flag and the second edge issues the request.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 10 | Level interrupt flags from the peripherals |
| src_en | input | 10 | Per-source enable |
| glb_en | input | 1 | Global enable |
| prio_hi | input | 10 | Upper priority bit per source |
| prio_lo | input | 10 | Lower priority bit per source |
| irq_ack | input | 1 | Core has entered the handler for the current request |
| irq_ret | input | 1 | Core has left the innermost handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the issued request |

## Verification
A corrupted in-service mask shows up at the ports as a wrong preemption decision. Either a request that should wait is issued within two cycles, or a request that should preempt never appears. So the bench follows every acknowledge and return with new flags at several levels. A wrong winner or a wrong vector is visible on the first cycle `irq_req` is high. A lost hold shows as a vector change before the acknowledge, which the bench compares on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic {
      LATCH_PASS = 1'b0,
      LATCH_REG  = 1'b1
   } latch_mode_e;

   function automatic int unsigned vec_of(input int unsigned idx,
                                          input int unsigned base,
                                          input int unsigned step);
      return base + step * idx;
   endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
   import irq_pkg::*;
#(
   parameter int          N_SRC = 10,
   parameter latch_mode_e MODE  = LATCH_REG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] raw,
   output logic [N_SRC-1:0] held
);

   if (MODE == LATCH_REG) begin : g_reg
      for (genvar i = 0; i < N_SRC; i++) begin : g_bit
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= raw[i];
         end
         assign held[i] = q;
      end
   end else begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign held = raw;
   end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
   parameter int N_LVL = 4,
   localparam int LVL_W = $clog2(N_LVL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [LVL_W-1:0] push_lvl,
   input  logic             pop,
   output logic [N_LVL-1:0] mask,
   output logic             busy,
   output logic [LVL_W-1:0] top_lvl
);

   logic [N_LVL-1:0] mask_q;
   logic [N_LVL-1:0] top_oh;
   logic [N_LVL-1:0] clr_vec;
   logic [N_LVL-1:0] set_vec;

   always_comb begin
      top_lvl = '0;
      for (int l = 0; l < N_LVL; l++) begin
         if (mask_q[l]) top_lvl = LVL_W'(l);
      end
   end

   assign busy    = |mask_q;
   assign top_oh  = busy ? (N_LVL'(1) << top_lvl) : '0;
   assign clr_vec = pop  ? top_oh : '0;
   assign set_vec = push ? (N_LVL'(1) << push_lvl) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q & ~clr_vec) | set_vec;
   end

   assign mask = mask_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int N_SRC = 10,
   parameter int N_LVL = 4,
   localparam int LVL_W = $clog2(N_LVL),
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]       cand,
   input  logic [N_SRC*LVL_W-1:0] lvl_flat,
   input  logic                   busy,
   input  logic [LVL_W-1:0]       top_lvl,
   output logic                   found,
   output logic [IDX_W-1:0]       win_idx,
   output logic [LVL_W-1:0]       win_lvl
);

   logic [N_SRC-1:0] elig;

   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      logic [LVL_W-1:0] lv;
      assign lv      = lvl_flat[i*LVL_W +: LVL_W];
      assign elig[i] = cand[i] && (!busy || (lv > top_lvl));
   end

   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (elig[i] && (!found || (lvl_flat[i*LVL_W +: LVL_W] > win_lvl))) begin
            found   = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lvl_flat[i*LVL_W +: LVL_W];
         end
      end
   end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import irq_pkg::*;
#(
   parameter int          N_SRC    = 10,
   parameter int          VEC_W    = 16,
   parameter int          VEC_BASE = 3,
   parameter int          VEC_STEP = 8,
   parameter latch_mode_e MODE     = LATCH_REG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_SRC-1:0] src_en,
   input  logic             glb_en,
   input  logic [N_SRC-1:0] prio_hi,
   input  logic [N_SRC-1:0] prio_lo,
   input  logic             irq_ack,
   input  logic             irq_ret,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec
);

   localparam int N_LVL   = 4;
   localparam int LVL_W   = $clog2(N_LVL);
   localparam int IDX_W   = $clog2(N_SRC);
   localparam int VEC_TOP = VEC_BASE + VEC_STEP * (N_SRC - 1);

   if (N_SRC < 2) begin : g_bad_nsrc
      $error("nest_irq_ctrl: N_SRC must be at least 2");
   end
   if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vecw
      $error("nest_irq_ctrl: VEC_W too narrow for the vector table");
   end

   logic [N_SRC-1:0]       req_q;
   logic [N_SRC-1:0]       cand;
   logic [N_SRC*LVL_W-1:0] lvl_flat;
   logic [N_LVL-1:0]       isr_mask;
   logic                   busy;
   logic [LVL_W-1:0]       top_lvl;
   logic                   found;
   logic [IDX_W-1:0]       win_idx;
   logic [LVL_W-1:0]       win_lvl;
   logic                   irq_req_q;
   logic [IDX_W-1:0]       sel_idx_q;
   logic [LVL_W-1:0]       sel_lvl_q;

   irq_src_latch #(.N_SRC(N_SRC), .MODE(MODE)) u_lat (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (src_req),
      .held (req_q)
   );

   assign cand = req_q & src_en & {N_SRC{glb_en}};

   for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
      assign lvl_flat[i*LVL_W +: LVL_W] = {prio_hi[i], prio_lo[i]};
   end

   irq_level_stack #(.N_LVL(N_LVL)) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (irq_req_q & irq_ack),
      .push_lvl(sel_lvl_q),
      .pop     (irq_ret),
      .mask    (isr_mask),
      .busy    (busy),
      .top_lvl (top_lvl)
   );

   irq_arbiter #(.N_SRC(N_SRC), .N_LVL(N_LVL)) u_arb (
      .cand    (cand),
      .lvl_flat(lvl_flat),
      .busy    (busy),
      .top_lvl (top_lvl),
      .found   (found),
      .win_idx (win_idx),
      .win_lvl (win_lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_req_q <= 1'b0;
         sel_idx_q <= '0;
         sel_lvl_q <= '0;
      end else if (irq_req_q) begin
         if (irq_ack) irq_req_q <= 1'b0;
      end else if (found) begin
         irq_req_q <= 1'b1;
         sel_idx_q <= win_idx;
         sel_lvl_q <= win_lvl;
      end
   end

   assign irq_req = irq_req_q;
   assign irq_vec = VEC_W'(vec_of(int'(sel_idx_q), VEC_BASE, VEC_STEP));

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int N_LVL = 4,
   parameter int VEC_W = 16,
   localparam int LVL_W = $clog2(N_LVL)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glb_en,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vec,
   input logic             irq_ack,
   input logic             irq_ret,
   input logic [N_LVL-1:0] isr,
   input logic [LVL_W-1:0] sel_lvl
);

   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec))); // R8

   AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> (!irq_req && isr[$past(sel_lvl)])); // R8

   AST_NO_ISSUE_GLB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !irq_req) |=> !irq_req); // R10

   AST_TOP_LEVEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (isr[N_LVL-1] && !irq_req) |=> !irq_req); // R7

   AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> (($past(isr) >> sel_lvl) == '0)); // R6

   AST_RET_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !(irq_req && irq_ack) && (isr != '0)) |=>
         (($countones(isr) + 1 == $countones($past(isr))) &&
          ((isr & ~$past(isr)) == '0))); // R9

endmodule

bind nest_irq_ctrl irq_ctrl_chk #(.N_LVL(N_LVL), .VEC_W(VEC_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .glb_en (glb_en),
   .irq_req(irq_req),
   .irq_vec(irq_vec),
   .irq_ack(irq_ack),
   .irq_ret(irq_ret),
   .isr    (isr_mask),
   .sel_lvl(sel_lvl_q)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;

   localparam int NS = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_req = '0, src_en = '0, prio_hi = '0, prio_lo = '0;
   logic          glb_en = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
   logic          irq_req;
   logic [15:0]   irq_vec;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   nest_irq_ctrl u0 (.*);

   // bench model built from the requirements
   logic [NS-1:0] m_reqq;
   logic          m_req;
   logic [3:0]    m_isr;
   logic [15:0]   m_vec;
   logic [1:0]    m_lvl;

   function automatic logic [6:0] arb(input logic [NS-1:0] rq, input logic [3:0] isr);
      logic f; logic [1:0] wl; logic [3:0] wi; logic [1:0] top; logic [1:0] lv;
      f = 0; wl = 0; wi = 0; top = 0;
      for (int l = 0; l < 4; l++) if (isr[l]) top = 2'(l);
      for (int i = 0; i < NS; i++) begin
         lv = {prio_hi[i], prio_lo[i]};
         if (rq[i] && src_en[i] && glb_en && (isr == 0 || lv > top) &&
             (!f || lv > wl)) begin
            f = 1; wl = lv; wi = 4'(i);
         end
      end
      return {f, wl, wi};
   endfunction

   always @(posedge clk) begin
      logic [6:0] a; logic [3:0] ni;
      if (!rst_n) begin
         m_reqq = '0; m_req = 0; m_isr = '0; m_vec = 16'h0003; m_lvl = 0;
      end else begin
         a = arb(m_reqq, m_isr);
         ni = m_isr;
         if (irq_ret && ni != 0) begin
            for (int l = 3; l >= 0; l--) if (ni[l]) begin ni[l] = 0; break; end
         end
         if (m_req && irq_ack) ni[m_lvl] = 1'b1;
         if (m_req) begin
            if (irq_ack) m_req = 0;
         end else if (a[6]) begin
            m_req = 1; m_lvl = a[5:4]; m_vec = 16'(3 + 8 * int'(a[3:0]));
         end
         m_isr = ni;
         m_reqq = src_req;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check({tag, " req"}, 32'(irq_req), 32'(m_req));
         if (m_req) check({tag, " vec"}, 32'(irq_vec), 32'(m_vec));
      end
   endtask

   task automatic pulse_ack(); irq_ack = 1; cyc(1, "R8 ack"); irq_ack = 0; endtask
   task automatic pulse_ret(); irq_ret = 1; cyc(1, "R9 ret"); irq_ret = 0; endtask

   task automatic set_lvl(input int i, input logic [1:0] l);
      prio_hi[i] = l[1]; prio_lo[i] = l[0];
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc(1, "R1");
      check("R1 reset req", 32'(irq_req), 0);

      // R11 latency and R5 tie-break at level 0
      glb_en = 1; src_en = '1;
      src_req = 10'b00_1000_1000;
      @(negedge clk); check("R11 after one edge", 32'(irq_req), 0);
      @(negedge clk); check("R11 after two edges", 32'(irq_req), 1);
      check("R5 tie lowest index", 32'(irq_vec), 32'h001B);
      cyc(3, "R8 hold");
      pulse_ack();
      cyc(4, "R6 same level waits");
      check("R6 same level waits", 32'(irq_req), 0);
      pulse_ret();
      cyc(1, "R9");
      check("R9 reissue after ret", 32'(irq_req), 1);
      check("R9 reissue vec", 32'(irq_vec), 32'h001B);
      src_req = '0;
      pulse_ack(); pulse_ret(); cyc(3, "idle");

      // R4 higher level wins
      set_lvl(7, 2); set_lvl(2, 1);
      src_req = 10'b00_1000_0100;
      cyc(2, "R4");
      check("R4 highest level", 32'(irq_vec), 32'h003B);
      src_req = '0;
      pulse_ack(); pulse_ret(); cyc(2, "idle");

      // R7 level 3 blocks, R6 strict preemption, R9 ordering
      set_lvl(0, 3); set_lvl(9, 2); set_lvl(4, 1);
      src_req = 10'b00_0000_0001;
      cyc(2, "R7");
      check("R7 level3 issued", 32'(irq_vec), 32'h0003);
      pulse_ack();
      src_req = 10'b10_0001_0000;
      cyc(4, "R7 blocked");
      check("R7 all blocked", 32'(irq_req), 0);
      pulse_ret();
      cyc(1, "R9");
      check("R9 level2 after pop", 32'(irq_vec), 32'h004B);
      pulse_ack();
      src_req = 10'b00_0001_0000;
      cyc(3, "R6 lower waits");
      check("R6 lower level waits", 32'(irq_req), 0);
      pulse_ret();
      cyc(1, "R9");
      check("R9 level1 after pop", 32'(irq_vec), 32'h0023);
      src_req = '0;
      pulse_ack(); pulse_ret(); cyc(2, "idle");
      prio_hi = '0; prio_lo = '0;

      // R3 and R10 masking
      src_req = 10'b00_0010_0000; src_en = 10'b11_1101_1111;
      cyc(4, "R3");
      check("R3 source disabled", 32'(irq_req), 0);
      src_en = '1; glb_en = 0;
      cyc(4, "R10");
      check("R10 global off", 32'(irq_req), 0);
      glb_en = 1;
      cyc(1, "R10");
      check("R10 global back on", 32'(irq_vec), 32'h002B);
      src_req = '0;
      pulse_ack(); pulse_ret(); cyc(2, "idle");

      // R2 vector for each source
      for (int i = 0; i < NS; i++) begin
         src_req = NS'(1) << i;
         cyc(2, "R2");
         check("R2 vector", 32'(irq_vec), 32'(3 + 8 * i));
         src_req = '0;
         pulse_ack(); pulse_ret(); cyc(1, "idle");
      end

      // constrained random traffic
      for (int t = 0; t < 4000; t++) begin
         src_req = NS'($urandom) & NS'($urandom);
         if ($urandom_range(0, 15) == 0) src_en = NS'($urandom) | NS'($urandom);
         if ($urandom_range(0, 31) == 0) glb_en = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 19) == 0) begin
            prio_hi = NS'($urandom); prio_lo = NS'($urandom);
         end
         irq_ack = m_req && ($urandom_range(0, 2) == 0);
         irq_ret = (m_isr != 0) && ($urandom_range(0, 4) == 0);
         cyc(1, "R4 R5 R6 R8 R9 random");
      end
      irq_ack = 0; irq_ret = 0;
      finish_run();
   end

endmodule